// File: doc/BRIEF.md
# UDP Readout Packet Engine

This block sits between a byte-wide Ethernet MAC stream and a detector readout path. It serves a host that polls it. The host sends one UDP request datagram inside an IPv4 frame. The engine checks the frame and writes the 18-byte control field of the datagram into a local register file as nine 16-bit words. It then sends back exactly one reply datagram, addressed to the host that sent the request.

The reply carries three things after its headers:
- an 18-byte status field taken from the register file's status vector;
- a payload of a length chosen at reply time;
- payload bytes pulled from the detector source over a ready/valid stream while the frame is being sent. No bulk buffer holds them.

The local MAC address, IPv4 address and UDP port are fixed by parameters. The engine answers no other protocol. A request that arrives while a reply is still going out is discarded, and a sticky overrun flag records it.

Byte offsets below count from the first byte of the frame (offset 0, marked by start-of-frame). Multi-byte fields are most significant byte first.

Top module: `udp_readout_engine`

## Requirements
- R1: A received frame is dropped with no register write and no reply unless all of these hold: bytes 12–13 equal 0x0800, byte 23 equals 17, and bytes 36–37 equal LOCAL_PORT.
- R2: For an accepted frame, bytes 42..59 are written as nine words, word k = {byte 42+2k, byte 43+2k}. Each word is written by a one-cycle ctl_we pulse with ctl_addr = k, in ascending order, and ctl_addr is never 9 or above.
- R3: A reply is started only when the accepted frame's end-of-frame byte is at offset 59 or later, and each such request produces exactly one reply.
- R4: The reply header has these fields, by offset:
  - 0–5: destination MAC = request bytes 6–11.
  - 6–11: source MAC = LOCAL_MAC.
  - 12–13: EtherType 0x0800.
  - 14–23: 0x45, 0x00, total length (16 bits), identification 0x0000, flags 0x4000, TTL 0x40, protocol 0x11.
  - 26–29: LOCAL_IP.
  - 30–33: request bytes 26–29.
  - 34–35: LOCAL_PORT.
  - 36–37: request bytes 34–35.
  - 38–39: UDP length.
  - 40–41: 0x0000 (UDP checksum).
  - Total length = 46+N and UDP length = 26+N, where N is the payload byte count.
- R5: Reply bytes 24–25 hold the IPv4 header checksum. The one's-complement sum of the ten 16-bit words at bytes 14–33 folds to 0xFFFF.
- R6: Reply bytes 42..59 are status byte j = sts_words[8*(17-j)+7 : 8*(17-j)], sampled when the reply starts.
- R7: N is pl_len sampled when the reply starts. Exactly N payload bytes are accepted (pl_valid and pl_ready both high), and they appear as reply bytes 60.. in the same order. Each accepted byte is on tx_data, with tx_valid high, in the next cycle.
- R8: A reply is 60+N consecutive valid bytes. tx_sof is high on the first byte only, tx_eof is high on the last byte only, and neither is high without tx_valid.
- R9: A frame whose start-of-frame arrives while a reply is pending or being sent writes no register and starts no reply. If it passes R1 and R3, overrun is set and stays set until reset.
- R10: During and right after reset, tx_valid, ctl_we, pl_ready and overrun are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_data | input | 8 | Received frame byte |
| rx_valid | input | 1 | rx_data carries a byte |
| rx_sof | input | 1 | First byte of a received frame |
| rx_eof | input | 1 | Last byte of a received frame |
| tx_data | output | 8 | Transmitted frame byte |
| tx_valid | output | 1 | tx_data carries a byte |
| tx_sof | output | 1 | First byte of a reply |
| tx_eof | output | 1 | Last byte of a reply |
| ctl_we | output | 1 | Control word write strobe |
| ctl_addr | output | $clog2(CTL_BYTES/2) | Control word index |
| ctl_wdata | output | 16 | Control word value |
| sts_words | input | 8*CTL_BYTES | Status field, first byte in the top bits |
| pl_len | input | LEN_W | Payload byte count for the next reply |
| pl_data | input | 8 | Payload byte from the detector source |
| pl_valid | input | 1 | Payload byte available |
| pl_ready | output | 1 | Engine accepts a payload byte |
| overrun | output | 1 | Sticky: a request arrived while busy |

## Verification
Well-formed requests are sent with random host addresses, control words, trailing data and idle gaps on the receive side. The payload lengths are zero, one and random, and the payload source stalls at random. These runs separate correct header fields, checksum, status order and payload order from errors that appear only at a length edge or when the stream stalls. Frames that differ from a good request in a single field (EtherType, protocol, either byte of the port), and one frame cut short inside the control field, show that each filter and the length rule acts on its own. A second request during a slow reply shows that captured host addresses and registers are protected, and that the overrun flag is set and held.

// File: rtl/udp_eng_pkg.sv
package udp_eng_pkg;
  localparam int unsigned ETH_HDR_BYTES = 14;
  localparam int unsigned IP_HDR_BYTES  = 20;
  localparam int unsigned UDP_HDR_BYTES = 8;
  localparam int unsigned HDR_BYTES     = ETH_HDR_BYTES + IP_HDR_BYTES + UDP_HDR_BYTES;

  localparam logic [15:0] ETYPE_IPV4  = 16'h0800;
  localparam logic [7:0]  IPPROTO_UDP = 8'd17;
  localparam logic [7:0]  IP_TTL      = 8'h40;
  localparam logic [15:0] IP_VER_IHL  = 16'h4500;
  localparam logic [15:0] IP_FLAGS_DF = 16'h4000;

  // receive-side offsets the filter and capture logic depend on
  localparam int unsigned OFS_SRC_MAC  = 6;
  localparam int unsigned OFS_ETYPE    = 12;
  localparam int unsigned OFS_PROTO    = 23;
  localparam int unsigned OFS_SRC_IP   = 26;
  localparam int unsigned OFS_SRC_PORT = 34;
  localparam int unsigned OFS_DST_PORT = 36;
  localparam int unsigned OFS_CTL      = HDR_BYTES;

  typedef enum logic [2:0] {
    TX_IDLE, TX_PREP, TX_HDR, TX_STS, TX_PAY
  } tx_state_e;

  function automatic logic [7:0] byte_of(input logic [63:0] v,
                                         input int unsigned nbytes,
                                         input int unsigned k);
    return 8'(v >> (8 * (nbytes - 1 - k)));
  endfunction
endpackage

// File: rtl/udp_rx_parser.sv
module udp_rx_parser
  import udp_eng_pkg::*;
#(
  parameter int unsigned CTL_BYTES  = 18,
  parameter int unsigned IDX_W      = 7,
  parameter logic [15:0] LOCAL_PORT = 16'd5000,
  localparam int unsigned ADDR_W    = $clog2(CTL_BYTES / 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [7:0]        rx_data,
  input  logic              rx_valid,
  input  logic              rx_sof,
  input  logic              rx_eof,
  input  logic              busy,
  output logic              ctl_we,
  output logic [ADDR_W-1:0] ctl_addr,
  output logic [15:0]       ctl_wdata,
  output logic              req_start,
  output logic              ovr_hit,
  output logic [47:0]       host_mac,
  output logic [31:0]       host_ip,
  output logic [15:0]       host_port
);
  localparam logic [IDX_W-1:0] I_SMAC  = IDX_W'(OFS_SRC_MAC);
  localparam logic [IDX_W-1:0] I_ETYPE = IDX_W'(OFS_ETYPE);
  localparam logic [IDX_W-1:0] I_PROTO = IDX_W'(OFS_PROTO);
  localparam logic [IDX_W-1:0] I_SIP   = IDX_W'(OFS_SRC_IP);
  localparam logic [IDX_W-1:0] I_SPORT = IDX_W'(OFS_SRC_PORT);
  localparam logic [IDX_W-1:0] I_DPORT = IDX_W'(OFS_DST_PORT);
  localparam logic [IDX_W-1:0] I_CTL   = IDX_W'(OFS_CTL);
  localparam logic [IDX_W-1:0] I_LAST  = IDX_W'(OFS_CTL + CTL_BYTES - 1);

  logic [IDX_W-1:0] cnt_q, idx;
  logic             match_q, blocked_q, match_now, blocked_now;
  logic [7:0]       hi_q;

  always_comb begin
    idx         = rx_sof ? '0 : cnt_q;
    blocked_now = rx_sof ? busy : blocked_q;
    match_now   = rx_sof ? 1'b1 : match_q;
    if (idx == I_ETYPE && rx_data != ETYPE_IPV4[15:8])          match_now = 1'b0;
    if (idx == I_ETYPE + 1'b1 && rx_data != ETYPE_IPV4[7:0])    match_now = 1'b0;
    if (idx == I_PROTO && rx_data != IPPROTO_UDP)               match_now = 1'b0;
    if (idx == I_DPORT && rx_data != LOCAL_PORT[15:8])          match_now = 1'b0;
    if (idx == I_DPORT + 1'b1 && rx_data != LOCAL_PORT[7:0])    match_now = 1'b0;
  end

  always_ff @(posedge clk) begin
    ctl_we    <= 1'b0;
    req_start <= 1'b0;
    ovr_hit   <= 1'b0;
    if (rst) begin
      cnt_q     <= '0;
      match_q   <= 1'b0;
      blocked_q <= 1'b0;
      ctl_addr  <= '0;
      ctl_wdata <= '0;
    end else if (rx_valid) begin
      cnt_q     <= (idx == '1) ? idx : idx + 1'b1;
      match_q   <= match_now && !rx_eof;
      blocked_q <= blocked_now;
      if (!blocked_now) begin
        if (idx >= I_SMAC && idx < I_ETYPE)         host_mac  <= {host_mac[39:0], rx_data};
        if (idx >= I_SIP && idx < I_SIP + 3'd4)     host_ip   <= {host_ip[23:0], rx_data};
        if (idx >= I_SPORT && idx < I_DPORT)        host_port <= {host_port[7:0], rx_data};
      end
      if (idx >= I_CTL && idx <= I_LAST) begin
        if (idx[0] == I_CTL[0]) begin
          hi_q <= rx_data;
        end else if (match_now && !blocked_now) begin
          ctl_we    <= 1'b1;
          ctl_addr  <= ADDR_W'((idx - I_CTL) >> 1);
          ctl_wdata <= {hi_q, rx_data};
        end
      end
      if (rx_eof && match_now && idx >= I_LAST) begin
        if (blocked_now) ovr_hit   <= 1'b1;
        else             req_start <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/udp_ip_csum.sv
module udp_ip_csum
  import udp_eng_pkg::*;
(
  input  logic [15:0] total_len,
  input  logic [31:0] src_ip,
  input  logic [31:0] dst_ip,
  output logic [15:0] csum
);
  localparam int unsigned NWORDS = IP_HDR_BYTES / 2;

  logic [15:0] w [NWORDS];
  logic [19:0] acc;
  logic [16:0] s1;
  logic [16:0] s2;

  always_comb begin
    w[0] = IP_VER_IHL;
    w[1] = total_len;
    w[2] = 16'h0000;
    w[3] = IP_FLAGS_DF;
    w[4] = {IP_TTL, IPPROTO_UDP};
    w[5] = 16'h0000;
    w[6] = src_ip[31:16];
    w[7] = src_ip[15:0];
    w[8] = dst_ip[31:16];
    w[9] = dst_ip[15:0];
    acc = '0;
    for (int i = 0; i < NWORDS; i++) acc = acc + 20'(w[i]);
    s1   = 17'(acc[15:0]) + 17'(acc[19:16]);
    s2   = 17'(s1[15:0]) + 17'(s1[16]);
    csum = ~s2[15:0];
  end
endmodule

// File: rtl/udp_tx_builder.sv
module udp_tx_builder
  import udp_eng_pkg::*;
#(
  parameter int unsigned CTL_BYTES  = 18,
  parameter int unsigned LEN_W      = 16,
  parameter logic [47:0] LOCAL_MAC  = 48'h02_00_00_00_00_01,
  parameter logic [31:0] LOCAL_IP   = 32'hC0A8_0A02,
  parameter logic [15:0] LOCAL_PORT = 16'd5000
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic [47:0]            host_mac,
  input  logic [31:0]            host_ip,
  input  logic [15:0]            host_port,
  input  logic [LEN_W-1:0]       pl_len,
  input  logic [8*CTL_BYTES-1:0] sts_flat,
  input  logic [7:0]             pl_data,
  input  logic                   pl_valid,
  output logic                   pl_ready,
  output logic [7:0]             tx_data,
  output logic                   tx_valid,
  output logic                   tx_sof,
  output logic                   tx_eof,
  output logic                   busy
);
  localparam int unsigned FIXED_LEN = IP_HDR_BYTES + UDP_HDR_BYTES + CTL_BYTES;
  localparam logic [5:0]  HDR_LAST  = 6'(HDR_BYTES - 1);
  localparam logic [5:0]  STS_LAST  = 6'(CTL_BYTES - 1);

  tx_state_e              state;
  logic [5:0]             idx;
  logic [LEN_W-1:0]       plen_q, pcnt;
  logic [15:0]            iplen_q, udplen_q, csum_q, iplen_c, csum_c;
  logic [8*CTL_BYTES-1:0] sts_q;
  logic [7:0]             hb, sb;
  int unsigned            k;

  assign iplen_c  = 16'(FIXED_LEN) + 16'(pl_len);
  assign pl_ready = (state == TX_PAY);
  assign busy     = (state != TX_IDLE);

  udp_ip_csum u_csum (
    .total_len(iplen_c),
    .src_ip   (LOCAL_IP),
    .dst_ip   (host_ip),
    .csum     (csum_c)
  );

  always_comb begin
    k  = 32'(idx);
    hb = 8'h00;
    if (k < 6)                 hb = byte_of(64'(host_mac), 6, k);
    else if (k < 12)           hb = byte_of(64'(LOCAL_MAC), 6, k - 6);
    else if (k < 14)           hb = byte_of(64'(ETYPE_IPV4), 2, k - 12);
    else if (k == 14)          hb = IP_VER_IHL[15:8];
    else if (k == 16 || k == 17) hb = byte_of(64'(iplen_q), 2, k - 16);
    else if (k == 20)          hb = IP_FLAGS_DF[15:8];
    else if (k == 22)          hb = IP_TTL;
    else if (k == 23)          hb = IPPROTO_UDP;
    else if (k == 24 || k == 25) hb = byte_of(64'(csum_q), 2, k - 24);
    else if (k >= 26 && k < 30) hb = byte_of(64'(LOCAL_IP), 4, k - 26);
    else if (k >= 30 && k < 34) hb = byte_of(64'(host_ip), 4, k - 30);
    else if (k >= 34 && k < 36) hb = byte_of(64'(LOCAL_PORT), 2, k - 34);
    else if (k >= 36 && k < 38) hb = byte_of(64'(host_port), 2, k - 36);
    else if (k >= 38 && k < 40) hb = byte_of(64'(udplen_q), 2, k - 38);
    sb = 8'(sts_q >> (8 * (CTL_BYTES - 1 - k)));
  end

  always_ff @(posedge clk) begin
    tx_valid <= 1'b0;
    tx_sof   <= 1'b0;
    tx_eof   <= 1'b0;
    if (rst) begin
      state   <= TX_IDLE;
      idx     <= '0;
      pcnt    <= '0;
      tx_data <= '0;
    end else begin
      case (state)
        TX_IDLE: if (start) state <= TX_PREP;
        TX_PREP: begin
          plen_q   <= pl_len;
          iplen_q  <= iplen_c;
          udplen_q <= iplen_c - 16'(IP_HDR_BYTES);
          csum_q   <= csum_c;
          sts_q    <= sts_flat;
          idx      <= '0;
          state    <= TX_HDR;
        end
        TX_HDR: begin
          tx_valid <= 1'b1;
          tx_data  <= hb;
          tx_sof   <= (idx == '0);
          if (idx == HDR_LAST) begin
            idx   <= '0;
            state <= TX_STS;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        TX_STS: begin
          tx_valid <= 1'b1;
          tx_data  <= sb;
          if (idx == STS_LAST) begin
            pcnt <= '0;
            if (plen_q == '0) begin
              tx_eof <= 1'b1;
              state  <= TX_IDLE;
            end else begin
              state <= TX_PAY;
            end
          end else begin
            idx <= idx + 1'b1;
          end
        end
        TX_PAY: if (pl_valid) begin
          tx_valid <= 1'b1;
          tx_data  <= pl_data;
          pcnt     <= pcnt + 1'b1;
          if (pcnt == plen_q - 1'b1) begin
            tx_eof <= 1'b1;
            state  <= TX_IDLE;
          end
        end
        default: state <= TX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/udp_readout_engine.sv
module udp_readout_engine
  import udp_eng_pkg::*;
#(
  parameter int unsigned CTL_BYTES  = 18,
  parameter int unsigned LEN_W      = 16,
  parameter logic [47:0] LOCAL_MAC  = 48'h02_00_00_00_00_01,
  parameter logic [31:0] LOCAL_IP   = 32'hC0A8_0A02,
  parameter logic [15:0] LOCAL_PORT = 16'd5000
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [7:0]                     rx_data,
  input  logic                           rx_valid,
  input  logic                           rx_sof,
  input  logic                           rx_eof,
  output logic [7:0]                     tx_data,
  output logic                           tx_valid,
  output logic                           tx_sof,
  output logic                           tx_eof,
  output logic                           ctl_we,
  output logic [$clog2(CTL_BYTES/2)-1:0] ctl_addr,
  output logic [15:0]                    ctl_wdata,
  input  logic [8*CTL_BYTES-1:0]         sts_words,
  input  logic [LEN_W-1:0]               pl_len,
  input  logic [7:0]                     pl_data,
  input  logic                           pl_valid,
  output logic                           pl_ready,
  output logic                           overrun
);
  localparam int unsigned IDX_W = $clog2(HDR_BYTES + CTL_BYTES + 1);

  logic        req_start, ovr_hit, tx_busy;
  logic [47:0] host_mac;
  logic [31:0] host_ip;
  logic [15:0] host_port;

  udp_rx_parser #(
    .CTL_BYTES (CTL_BYTES),
    .IDX_W     (IDX_W),
    .LOCAL_PORT(LOCAL_PORT)
  ) u_rx (
    .clk      (clk),
    .rst      (rst),
    .rx_data  (rx_data),
    .rx_valid (rx_valid),
    .rx_sof   (rx_sof),
    .rx_eof   (rx_eof),
    .busy     (tx_busy | req_start),
    .ctl_we   (ctl_we),
    .ctl_addr (ctl_addr),
    .ctl_wdata(ctl_wdata),
    .req_start(req_start),
    .ovr_hit  (ovr_hit),
    .host_mac (host_mac),
    .host_ip  (host_ip),
    .host_port(host_port)
  );

  udp_tx_builder #(
    .CTL_BYTES (CTL_BYTES),
    .LEN_W     (LEN_W),
    .LOCAL_MAC (LOCAL_MAC),
    .LOCAL_IP  (LOCAL_IP),
    .LOCAL_PORT(LOCAL_PORT)
  ) u_tx (
    .clk      (clk),
    .rst      (rst),
    .start    (req_start),
    .host_mac (host_mac),
    .host_ip  (host_ip),
    .host_port(host_port),
    .pl_len   (pl_len),
    .sts_flat (sts_words),
    .pl_data  (pl_data),
    .pl_valid (pl_valid),
    .pl_ready (pl_ready),
    .tx_data  (tx_data),
    .tx_valid (tx_valid),
    .tx_sof   (tx_sof),
    .tx_eof   (tx_eof),
    .busy     (tx_busy)
  );

  always_ff @(posedge clk) begin
    if (rst)          overrun <= 1'b0;
    else if (ovr_hit) overrun <= 1'b1;
  end
endmodule

// File: rtl/udp_engine_chk.sv
module udp_engine_chk #(
  parameter int unsigned CTL_BYTES = 18
) (
  input logic                           clk,
  input logic                           rst,
  input logic [7:0]                     tx_data,
  input logic                           tx_valid,
  input logic                           tx_sof,
  input logic                           tx_eof,
  input logic                           ctl_we,
  input logic [$clog2(CTL_BYTES/2)-1:0] ctl_addr,
  input logic [7:0]                     pl_data,
  input logic                           pl_valid,
  input logic                           pl_ready,
  input logic                           overrun
);
  localparam int unsigned NWORDS = CTL_BYTES / 2;

  a_r2_addr_in_range: assert property (@(posedge clk) disable iff (rst)
    ctl_we |-> (32'(ctl_addr) < NWORDS));

  a_r7_payload_forwarded: assert property (@(posedge clk) disable iff (rst)
    (pl_valid && pl_ready) |=> (tx_valid && tx_data == $past(pl_data)));

  a_r8_markers_need_valid: assert property (@(posedge clk) disable iff (rst)
    (tx_sof || tx_eof) |-> tx_valid);

  a_r8_single_sof: assert property (@(posedge clk) disable iff (rst)
    tx_sof |=> !tx_sof);

  a_r9_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun);

  a_r9_no_write_during_reply: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> !ctl_we);
endmodule

bind udp_readout_engine udp_engine_chk #(.CTL_BYTES(CTL_BYTES)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .tx_data (tx_data),
  .tx_valid(tx_valid),
  .tx_sof  (tx_sof),
  .tx_eof  (tx_eof),
  .ctl_we  (ctl_we),
  .ctl_addr(ctl_addr),
  .pl_data (pl_data),
  .pl_valid(pl_valid),
  .pl_ready(pl_ready),
  .overrun (overrun)
);

// File: tb/sim_udp_readout_engine.sv
module sim_udp_readout_engine;
  localparam int CB = 18;
  localparam int NW = 9;
  localparam logic [47:0] LMAC  = 48'h02_00_00_00_00_01;
  localparam logic [31:0] LIP   = 32'hC0A8_0A02;
  localparam logic [15:0] LPORT = 16'd5000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [7:0]    rx_data = '0;
  logic          rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0;
  logic [7:0]    tx_data;
  logic          tx_valid, tx_sof, tx_eof, ctl_we, pl_ready, overrun;
  logic [3:0]    ctl_addr;
  logic [15:0]   ctl_wdata;
  logic [8*CB-1:0] sts_words = '0;
  logic [15:0]   pl_len = '0;
  logic [7:0]    pl_data = '0;
  logic          pl_valid = 1'b0;

  always #10 clk = ~clk;

  udp_readout_engine #(.CTL_BYTES(CB), .LEN_W(16), .LOCAL_MAC(LMAC),
                       .LOCAL_IP(LIP), .LOCAL_PORT(LPORT)) u0 (.*);

  int n_chk = 0, n_fail = 0;
  logic [7:0]  rq  [0:511];
  logic [7:0]  txb [0:1023];
  logic [15:0] regs_m [0:NW-1];
  logic [15:0] ctl_m  [0:NW-1];
  int tx_cnt = 0, tx_frames = 0, tx_last_len = 0, n_wr = 0;
  int ptr = 0, hs_total = 0, gap = 30;
  bit pend = 1'b0;

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(int p);
    return 8'(p * 37 + 11);
  endfunction

  // output monitor and payload source
  initial forever begin
    @(negedge clk);
    if (ctl_we) begin
      if (ctl_addr < NW) regs_m[ctl_addr] = ctl_wdata;
      n_wr++;
    end
    if (tx_valid) begin
      if (tx_sof != (tx_cnt == 0)) chk(0, "R8 sof position", 64'(tx_cnt), 0);
      txb[tx_cnt] = tx_data;
      tx_cnt++;
      if (tx_eof) begin
        tx_last_len = tx_cnt;
        tx_cnt = 0;
        tx_frames++;
      end
    end else if (tx_sof || tx_eof) chk(0, "R8 marker without valid", 1, 0);
    if (pend) ptr++;
    pl_valid = (($urandom % 100) >= gap);
    pl_data  = pat(ptr);
    pend     = pl_valid && pl_ready;
    if (pend) hs_total++;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  task automatic build_req(logic [47:0] hm, logic [31:0] hip, logic [15:0] hp,
                           logic [15:0] et, logic [7:0] pr, logic [15:0] dp,
                           int extra, output int len);
    len = 60 + extra;
    for (int i = 0; i < 6; i++) begin
      rq[i] = LMAC[8*(5-i) +: 8];
      rq[6+i] = hm[8*(5-i) +: 8];
    end
    rq[12] = et[15:8]; rq[13] = et[7:0];
    rq[14] = 8'h45; rq[15] = 8'h00;
    rq[16] = 8'(16'(len - 14) >> 8); rq[17] = 8'(len - 14);
    for (int i = 18; i < 22; i++) rq[i] = 8'h00;
    rq[22] = 8'h40; rq[23] = pr; rq[24] = 8'h00; rq[25] = 8'h00;
    for (int i = 0; i < 4; i++) begin
      rq[26+i] = hip[8*(3-i) +: 8];
      rq[30+i] = LIP[8*(3-i) +: 8];
    end
    rq[34] = hp[15:8]; rq[35] = hp[7:0];
    rq[36] = dp[15:8]; rq[37] = dp[7:0];
    rq[38] = 8'(16'(len - 34) >> 8); rq[39] = 8'(len - 34);
    rq[40] = 8'h00; rq[41] = 8'h00;
    for (int i = 0; i < NW; i++) begin
      rq[42+2*i] = ctl_m[i][15:8];
      rq[43+2*i] = ctl_m[i][7:0];
    end
    for (int i = 60; i < len; i++) rq[i] = 8'($urandom);
  endtask

  task automatic send_frame(int len);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if ($urandom % 4 == 0) begin
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
        @(negedge clk);
      end
      rx_valid = 1'b1; rx_data = rq[i];
      rx_sof = (i == 0); rx_eof = (i == len - 1);
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
  endtask

  task automatic randomize_inputs(int n);
    for (int i = 0; i < NW; i++) ctl_m[i] = 16'($urandom);
    for (int i = 0; i < CB; i++) sts_words[8*i +: 8] = 8'($urandom);
    pl_len = 16'(n);
  endtask

  task automatic wait_frames(int target);
    int t = 0;
    while (tx_frames < target && t < 6000) begin @(negedge clk); t++; end
    chk(tx_frames >= target, "R3 reply produced", 64'(tx_frames), 64'(target));
  endtask

  task automatic check_reply(logic [47:0] hm, logic [31:0] hip, logic [15:0] hp,
                             int n, int base, logic [8*CB-1:0] sts);
    logic [7:0]  ex [0:41];
    logic [15:0] tl, ul;
    logic [31:0] s;
    tl = 16'(46 + n); ul = 16'(26 + n);
    for (int i = 0; i < 42; i++) ex[i] = 8'h00;
    for (int i = 0; i < 6; i++) begin
      ex[i] = hm[8*(5-i) +: 8];
      ex[6+i] = LMAC[8*(5-i) +: 8];
    end
    ex[12] = 8'h08; ex[14] = 8'h45; ex[16] = tl[15:8]; ex[17] = tl[7:0];
    ex[20] = 8'h40; ex[22] = 8'h40; ex[23] = 8'h11;
    for (int i = 0; i < 4; i++) begin
      ex[26+i] = LIP[8*(3-i) +: 8];
      ex[30+i] = hip[8*(3-i) +: 8];
    end
    ex[34] = LPORT[15:8]; ex[35] = LPORT[7:0];
    ex[36] = hp[15:8]; ex[37] = hp[7:0];
    ex[38] = ul[15:8]; ex[39] = ul[7:0];
    s = 0;
    for (int i = 14; i < 34; i += 2) s += {16'h0, ex[i], ex[i+1]};
    s = {16'h0, s[15:0]} + {16'h0, s[31:16]};
    s = {16'h0, s[15:0]} + {16'h0, s[31:16]};
    ex[24] = ~s[15:8]; ex[25] = ~s[7:0];
    chk(tx_last_len == 60 + n, "R8 reply length", 64'(tx_last_len), 64'(60 + n));
    for (int i = 0; i < 42; i++)
      if (i != 24 && i != 25)
        chk(txb[i] == ex[i], $sformatf("R4 header byte %0d", i), txb[i], ex[i]);
    chk({txb[24], txb[25]} == {ex[24], ex[25]}, "R5 checksum value",
        {txb[24], txb[25]}, {ex[24], ex[25]});
    s = 0;
    for (int i = 14; i < 34; i += 2) s += {16'h0, txb[i], txb[i+1]};
    s = {16'h0, s[15:0]} + {16'h0, s[31:16]};
    s = {16'h0, s[15:0]} + {16'h0, s[31:16]};
    chk(s[15:0] == 16'hFFFF, "R5 checksum fold", s[15:0], 16'hFFFF);
    for (int j = 0; j < CB; j++)
      chk(txb[42+j] == sts[8*(CB-1-j) +: 8], $sformatf("R6 status byte %0d", j),
          txb[42+j], sts[8*(CB-1-j) +: 8]);
    for (int j = 0; j < n; j++)
      chk(txb[60+j] == pat(base + j), $sformatf("R7 payload byte %0d", j),
          txb[60+j], pat(base + j));
  endtask

  task automatic check_regs(string tag);
    for (int i = 0; i < NW; i++)
      chk(regs_m[i] == ctl_m[i], tag, regs_m[i], ctl_m[i]);
  endtask

  initial begin
    logic [47:0] hm;
    logic [31:0] hip;
    logic [15:0] hp;
    logic [8*CB-1:0] sts_a;
    logic [15:0] saved [0:NW-1];
    int len, n, fr0, wr0, hs0, base;
    void'($urandom(32'd4242));
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(!tx_valid, "R10 tx_valid in reset", 64'(tx_valid), 0);
    chk(!ctl_we, "R10 ctl_we in reset", 64'(ctl_we), 0);
    chk(!pl_ready, "R10 pl_ready in reset", 64'(pl_ready), 0);
    chk(!overrun, "R10 overrun in reset", 64'(overrun), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!tx_valid && !ctl_we && !pl_ready && !overrun, "R10 after reset",
        {tx_valid, ctl_we, pl_ready, overrun}, 0);

    // well-formed requests: lengths 0, 1 and random
    for (int it = 0; it < 12; it++) begin
      n = (it == 0) ? 0 : (it == 1) ? 1 : int'($urandom % 120);
      gap = (it % 3) * 30;
      hm = {16'($urandom), 32'($urandom)}; hip = 32'($urandom); hp = 16'($urandom);
      randomize_inputs(n);
      build_req(hm, hip, hp, 16'h0800, 8'd17, LPORT, int'($urandom % 6), len);
      fr0 = tx_frames; wr0 = n_wr; hs0 = hs_total; base = ptr;
      send_frame(len);
      wait_frames(fr0 + 1);
      repeat (20) @(negedge clk);
      chk(tx_frames == fr0 + 1, "R3 exactly one reply", 64'(tx_frames), 64'(fr0 + 1));
      chk(n_wr - wr0 == NW, "R2 write count", 64'(n_wr - wr0), NW);
      chk(hs_total - hs0 == n, "R7 handshake count", 64'(hs_total - hs0), 64'(n));
      check_regs("R2 control words");
      check_reply(hm, hip, hp, n, base, sts_words);
    end

    // frames failing one filter each: no writes, no reply
    for (int b = 0; b < 4; b++) begin
      for (int i = 0; i < NW; i++) saved[i] = ctl_m[i];
      for (int i = 0; i < NW; i++) ctl_m[i] = 16'($urandom);
      build_req(48'h0A0B0C0D0E0F, 32'h0A000001, 16'h1234,
                (b == 0) ? 16'h86DD : 16'h0800, (b == 1) ? 8'd6 : 8'd17,
                (b == 2) ? (LPORT ^ 16'h0100) : (b == 3) ? (LPORT ^ 16'h0001) : LPORT,
                0, len);
      for (int i = 0; i < NW; i++) ctl_m[i] = saved[i];
      fr0 = tx_frames; wr0 = n_wr;
      send_frame(len);
      repeat (150) @(negedge clk);
      chk(tx_frames == fr0, $sformatf("R1 filter %0d no reply", b), 64'(tx_frames), 64'(fr0));
      chk(n_wr == wr0, $sformatf("R1 filter %0d no write", b), 64'(n_wr), 64'(wr0));
      check_regs("R1 registers unchanged");
    end

    // frame ending inside the control field
    randomize_inputs(4);
    build_req(48'h0A0B0C0D0E0F, 32'h0A000001, 16'h1234, 16'h0800, 8'd17, LPORT, 0, len);
    fr0 = tx_frames;
    send_frame(50);
    repeat (150) @(negedge clk);
    chk(tx_frames == fr0, "R3 short frame no reply", 64'(tx_frames), 64'(fr0));

    // request arriving during a slow reply
    gap = 90; n = 100;
    hm = 48'h0200_1122_3344; hip = 32'h0A00_0063; hp = 16'hBEEF;
    randomize_inputs(n);
    sts_a = sts_words;
    build_req(hm, hip, hp, 16'h0800, 8'd17, LPORT, 2, len);
    fr0 = tx_frames; base = ptr;
    send_frame(len);
    while (tx_cnt == 0) @(negedge clk);
    for (int i = 0; i < NW; i++) saved[i] = ctl_m[i];
    for (int i = 0; i < NW; i++) ctl_m[i] = 16'($urandom);
    build_req(48'h0200_9999_8888, 32'h0A00_0077, 16'h4444, 16'h0800, 8'd17, LPORT, 0, len);
    for (int i = 0; i < NW; i++) ctl_m[i] = saved[i];
    wr0 = n_wr;
    send_frame(len);
    repeat (3) @(negedge clk);
    chk(n_wr == wr0, "R9 no write while busy", 64'(n_wr), 64'(wr0));
    chk(overrun == 1'b1, "R9 overrun set", 64'(overrun), 1);
    wait_frames(fr0 + 1);
    repeat (200) @(negedge clk);
    chk(tx_frames == fr0 + 1, "R9 ignored request gives no reply", 64'(tx_frames), 64'(fr0 + 1));
    check_regs("R9 registers keep first request");
    check_reply(hm, hip, hp, n, base, sts_a);

    // sticky flag survives a later good request
    gap = 0;
    randomize_inputs(3);
    build_req(hm, hip, hp, 16'h0800, 8'd17, LPORT, 0, len);
    fr0 = tx_frames; base = ptr;
    send_frame(len);
    wait_frames(fr0 + 1);
    repeat (10) @(negedge clk);
    check_reply(hm, hip, hp, 3, base, sts_words);
    chk(overrun == 1'b1, "R9 overrun sticky", 64'(overrun), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule